// File: doc/BRIEF.md
# Serial Converter Result Reader

This block is the host side of a link to a 10-bit serial analog-to-digital converter that uses SPI mode with clock polarity 0 and phase 1. When it sees a start request it pulls chip select low and generates the serial clock from the system clock, with a programmable half-period. Before returning a result it drops the six padding bits that open every frame. The result comes back left-aligned in a 10-bit word, together with a one-cycle done strobe.

A frame normally runs as one unbroken burst of 6 + resolution clocks. If the split option is set, the clock stops low after the eighth falling edge and chip select stays low for a programmable number of system cycles before the second burst begins. Asking for fewer than 10 result bits shortens the frame, and chip select is then released early. After every frame chip select stays high for one full serial clock period, which lets the converter restart its frame. The frame-sync output is held high, which is the level that selects this mode on the converter.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, busy and done are low, the result is zero and the gap error flag is low.
- R2: The serial clock is low whenever chip select is high. Each high pulse and each regular low phase lasts H system cycles, where H = max(div_i, MIN_HALF).
- R3: A frame contains exactly 6 + R rising serial clock edges. R is res_i clamped to the range 1..10: a value of 0 counts as 1 and a value above 10 counts as 10. Input data is sampled on each falling edge.
- R4: The bits sampled on the first six falling edges are discarded. The following R bits fill data_o from bit 9 downward, most significant first, and any bits that were not read are zero. data_o changes only when done_o is high.
- R5: When split_i is set and the frame is longer than 8 clocks, the clock stays low and chip select stays low for an extra gap_i system cycles between the eighth falling edge and the ninth rising edge. A gap_i of 0 adds no delay.
- R6: gap_err_o is high, one cycle after gap_i is applied, exactly when gap_i exceeds CLK_HZ/10000 system cycles, which is the 100 µs limit.
- R7: After the last falling edge, chip select rises H cycles later and then stays high for 2H cycles. After that, done_o pulses for one cycle and busy_o falls in the same cycle. Measured from the edge that accepts the start, done occurs 2·H·(6+R) + 3H (+ gap_i when split) cycles later.
- R8: A start request that arrives while busy_o is high is ignored. No second frame and no second done pulse follow from it.
- R9: fs_o is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion read |
| res_i | input | 4 | Requested result bits, 1..10 |
| split_i | input | 1 | Run the frame as two bursts with a gap after the eighth clock |
| div_i | input | DIV_W | Serial clock half-period in system cycles |
| gap_i | input | GAP_W | Gap between the bursts in system cycles |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock, idles low |
| csn_o | output | 1 | Chip select, active low |
| fs_o | output | 1 | Frame-sync level, held high |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle strobe when a result is ready |
| data_o | output | 10 | Left-aligned result |
| gap_err_o | output | 1 | The configured gap exceeds 100 µs |

## Verification
The done strobe follows the accepting clock edge by exactly 2·H·(6+R)+3H cycles, plus gap_i for split frames. The driver counts cycles from the start it issues and checks the done strobe against that total, so errors in the gap, the tail and the chip-select high time show up as latency errors. The monitor measures the width of every high clock pulse against H, and it counts rising edges per frame against 6+R. It compares each result with the queued expected word in the cycle done is high. gap_err_o is due one cycle after gap_i changes, and the bench samples it two cycles later.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  localparam int PAD_BITS = 6;
  localparam int SPLIT_AT = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_HIGH, S_LOW, S_GAP, S_TAIL, S_CSHI
  } rd_state_t;
endpackage

// File: rtl/adcr_tick.sv
module adcr_tick #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = en && (cnt == lim - W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en) cnt <= hit ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/adcr_capture.sv
module adcr_capture #(
  parameter int RESULT_W = 10,
  parameter int PAD      = 6,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                take,
  input  logic [CNT_W-1:0]    idx,
  input  logic                din,
  output logic [RESULT_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clr) word <= '0;
    else if (take) begin
      for (int i = 0; i < RESULT_W; i++)
        if (idx == CNT_W'(PAD + i)) word[RESULT_W-1-i] <= din;
    end
  end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int          RESULT_W = 10,
  parameter int          DIV_W    = 8,
  parameter int          GAP_W    = 16,
  parameter int          MIN_HALF = 5,
  parameter longint      CLK_HZ   = 200000000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [3:0]          res_i,
  input  logic                split_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic [GAP_W-1:0]    gap_i,
  input  logic                miso_i,
  output logic                sclk_o,
  output logic                csn_o,
  output logic                fs_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [RESULT_W-1:0] data_o,
  output logic                gap_err_o
);
  import adcr_pkg::*;

  localparam int     CNT_W     = $clog2(PAD_BITS + RESULT_W + 1);
  localparam longint GAP_LIMIT = CLK_HZ / 10000;

  rd_state_t            st;
  logic [DIV_W-1:0]     half_q, half_eff;
  logic [CNT_W-1:0]     nbits_q, bitcnt;
  logic [3:0]           res_eff;
  logic                 split_q;
  logic [GAP_W-1:0]     gap_q;
  logic [DIV_W:0]       ph_lim;
  logic                 ph_en, ph_hit, gap_hit, accept, take;
  logic [RESULT_W-1:0]  acc;

  assign fs_o     = 1'b1;
  assign half_eff = (div_i < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : div_i;
  assign res_eff  = (res_i == 4'd0) ? 4'd1 :
                    (32'(res_i) > RESULT_W) ? 4'(RESULT_W) : res_i;
  assign accept   = (st == S_IDLE) && start_i;
  assign take     = (st == S_HIGH) && ph_hit;
  assign ph_en    = (st != S_IDLE) && (st != S_GAP);
  assign ph_lim   = (st == S_CSHI) ? {half_q, 1'b0} : {1'b0, half_q};

  adcr_tick #(.W(DIV_W + 1)) i_phase (
    .clk(clk), .rst(rst), .clr(accept), .en(ph_en), .lim(ph_lim), .hit(ph_hit)
  );

  adcr_tick #(.W(GAP_W)) i_gap (
    .clk(clk), .rst(rst), .clr(accept), .en(st == S_GAP), .lim(gap_q), .hit(gap_hit)
  );

  adcr_capture #(.RESULT_W(RESULT_W), .PAD(PAD_BITS), .CNT_W(CNT_W)) i_cap (
    .clk(clk), .rst(rst), .clr(accept), .take(take), .idx(bitcnt), .din(miso_i), .word(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      sclk_o    <= 1'b0;
      csn_o     <= 1'b1;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      data_o    <= '0;
      gap_err_o <= 1'b0;
      half_q    <= DIV_W'(MIN_HALF);
      nbits_q   <= '0;
      bitcnt    <= '0;
      split_q   <= 1'b0;
      gap_q     <= '0;
    end else begin
      done_o    <= 1'b0;
      gap_err_o <= (64'(gap_i) > 64'(GAP_LIMIT));
      case (st)
        S_IDLE: if (start_i) begin
          half_q  <= half_eff;
          nbits_q <= CNT_W'(PAD_BITS) + CNT_W'(res_eff);
          split_q <= split_i;
          gap_q   <= gap_i;
          bitcnt  <= '0;
          csn_o   <= 1'b0;
          busy_o  <= 1'b1;
          st      <= S_LEAD;
        end
        S_LEAD: if (ph_hit) begin
          sclk_o <= 1'b1;
          st     <= S_HIGH;
        end
        S_HIGH: if (ph_hit) begin
          sclk_o <= 1'b0;
          bitcnt <= bitcnt + CNT_W'(1);
          st     <= (bitcnt + CNT_W'(1) == nbits_q) ? S_TAIL : S_LOW;
        end
        S_LOW: if (ph_hit) begin
          if (split_q && bitcnt == CNT_W'(SPLIT_AT) && gap_q != '0) begin
            st <= S_GAP;
          end else begin
            sclk_o <= 1'b1;
            st     <= S_HIGH;
          end
        end
        S_GAP: if (gap_hit) begin
          sclk_o <= 1'b1;
          st     <= S_HIGH;
        end
        S_TAIL: if (ph_hit) begin
          csn_o <= 1'b1;
          st    <= S_CSHI;
        end
        S_CSHI: if (ph_hit) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          data_o <= acc;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adcr_chk.sv
module adcr_chk #(
  parameter int RESULT_W = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                sclk_o,
  input logic                csn_o,
  input logic                busy_o,
  input logic                done_o,
  input logic [RESULT_W-1:0] data_o
);
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
    csn_o |-> !sclk_o);
  p_sclk_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> busy_o);
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_busy_end_done_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
  p_idle_cs_high_r7: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> csn_o);
  p_cs_fall_idle_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(csn_o) |-> $rose(busy_o));
  p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(data_o));
endmodule

bind adc_serial_reader adcr_chk #(.RESULT_W(RESULT_W)) i_adcr_chk (
  .clk(clk), .rst(rst), .sclk_o(sclk_o), .csn_o(csn_o),
  .busy_o(busy_o), .done_o(done_o), .data_o(data_o)
);

// File: tb/test_adc_serial_reader.sv
module test_adc_serial_reader;
  localparam int DIV_W = 8, GAP_W = 16, MIN_HALF = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, split_i = 0, miso_i = 0;
  logic [3:0] res_i = 4'd10;
  logic [DIV_W-1:0] div_i = 8'd5;
  logic [GAP_W-1:0] gap_i = '0;
  logic sclk_o, csn_o, fs_o, busy_o, done_o, gap_err_o;
  logic [9:0] data_o;

  always #2.5 clk = ~clk;

  adc_serial_reader i_adc_serial_reader (
    .clk(clk), .rst(rst), .start_i(start_i), .res_i(res_i), .split_i(split_i),
    .div_i(div_i), .gap_i(gap_i), .miso_i(miso_i), .sclk_o(sclk_o), .csn_o(csn_o),
    .fs_o(fs_o), .busy_o(busy_o), .done_o(done_o), .data_o(data_o), .gap_err_o(gap_err_o)
  );

  int n_checks = 0, n_errors = 0;
  int cur_half = MIN_HALF;
  int hi_run = 0;
  int rises = 0;
  logic [15:0] frame = '0;
  int slv_idx = 0;
  logic [9:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // converter model: drives the next frame bit on each rising clock edge
  always @(posedge sclk_o or posedge csn_o) begin
    if (csn_o) slv_idx <= 0;
    else begin
      miso_i  <= frame[15 - slv_idx];
      slv_idx <= slv_idx + 1;
    end
  end

  always @(posedge sclk_o) rises <= rises + 1;

  // monitor: scoreboard and clock pulse width
  always @(negedge clk) begin
    if (!rst) begin
      if (sclk_o) hi_run <= hi_run + 1;
      else if (hi_run > 0) begin
        chk(hi_run == cur_half, "R2", "sclk high width", hi_run, cur_half);
        hi_run <= 0;
      end
      if (done_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected done", 1, 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk(data_o == e, "R4", "result", int'(data_o), int'(e));
        end
      end
    end
  end

  task automatic xfer(input int div, input int res, input bit split, input int gap,
                      input logic [9:0] smp, input logic [5:0] pd, input bit poke,
                      input string req);
    int h, r, n, d, k, r0;
    logic [9:0] e;
    h = (div < MIN_HALF) ? MIN_HALF : div;
    r = (res == 0) ? 1 : (res > 10 ? 10 : res);
    n = 6 + r;
    e = '0;
    for (int i = 0; i < r; i++) e[9-i] = smp[9-i];
    d = 2*h*n + 3*h + ((split && n > 8) ? gap : 0);
    @(negedge clk);
    cur_half = h;
    frame = {pd, smp};
    div_i = DIV_W'(div); res_i = 4'(res); split_i = split; gap_i = GAP_W'(gap);
    r0 = rises;
    exp_q.push_back(e);
    start_i = 1'b1;
    k = 0;
    while (k < 5000) begin
      @(negedge clk);
      k++;
      if (k == 1) start_i = 1'b0;
      if (poke && k == 20) start_i = 1'b1;
      if (poke && k == 22) start_i = 1'b0;
      if (done_o) break;
    end
    chk(k == d + 1, req, "done latency", k - 1, d);
    chk(rises - r0 == n, "R3", "rising edges", rises - r0, n);
    chk(csn_o && !busy_o, "R7", "cs high and idle at done", int'(csn_o), 1);
    repeat (3) @(negedge clk);
    chk(!busy_o && csn_o, "R8", "no restart after frame", int'(busy_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7", "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk(csn_o == 1'b1, "R1", "csn after reset", int'(csn_o), 1);
    chk(sclk_o == 1'b0, "R1", "sclk after reset", int'(sclk_o), 0);
    chk(!busy_o && !done_o, "R1", "busy/done after reset", int'(busy_o), 0);
    chk(data_o == '0, "R1", "data after reset", int'(data_o), 0);
    chk(gap_err_o == 1'b0, "R1", "gap_err after reset", int'(gap_err_o), 0);
    chk(fs_o == 1'b1, "R9", "fs level", int'(fs_o), 1);

    xfer(5, 10, 0, 0, 10'h2A5, 6'h00, 0, "R7");
    xfer(5, 10, 0, 0, 10'h155, 6'h3F, 0, "R4");   // padding bits discarded
    xfer(5, 8, 0, 0, 10'h3FF, 6'h00, 0, "R3");    // 14-clock frame -> 3FC
    xfer(5, 1, 0, 0, 10'h3FF, 6'h15, 0, "R3");    // single bit
    xfer(5, 0, 0, 0, 10'h3FF, 6'h00, 0, "R3");    // 0 counts as 1
    xfer(5, 15, 0, 0, 10'h0F3, 6'h00, 0, "R3");   // clamped to 10
    xfer(2, 10, 0, 0, 10'h1C7, 6'h00, 0, "R2");   // half clamped to MIN_HALF
    xfer(7, 10, 0, 0, 10'h338, 6'h00, 0, "R2");
    xfer(5, 10, 1, 40, 10'h2D2, 6'h00, 0, "R5");
    xfer(5, 2, 1, 40, 10'h3FF, 6'h00, 0, "R5");   // 8 clocks: no gap
    xfer(6, 10, 1, 0, 10'h0AB, 6'h00, 0, "R5");   // zero gap
    xfer(5, 10, 0, 0, 10'h321, 6'h00, 1, "R8");   // start while busy ignored
    chk(fs_o == 1'b1, "R9", "fs level after frames", int'(fs_o), 1);

    @(negedge clk) gap_i = 16'd20001;
    repeat (2) @(negedge clk);
    chk(gap_err_o == 1'b1, "R6", "gap over limit", int'(gap_err_o), 1);
    @(negedge clk) gap_i = 16'd20000;
    repeat (2) @(negedge clk);
    chk(gap_err_o == 1'b0, "R6", "gap at limit", int'(gap_err_o), 0);
    chk(exp_q.size() == 0, "R8", "pending results", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule